// File: doc/BRIEF.md
# Stopwatch Lap and Split Recorder

This block is the counting core of a hundredths-of-a-second stopwatch. A 100 Hz tick enable drives two BCD time counters: an elapsed counter that runs from the first start until a reset, and a lap counter that restarts on every lap capture. One-cycle strobes start and stop counting, capture an entry, clear a stopped watch, and switch between lap and split operation. Each capture is written with a two-digit BCD sequence number into a ten-deep circular store. When the store is full, a new capture overwrites the oldest entry.

In lap mode the block keeps the shortest complete lap seen so far. A flag blinks at 2 Hz while the most recent capture is that best lap. A recall port walks the stored entries from oldest to newest and marks the entry that holds the best lap. Display decoding, zero suppression, sound and switch conditioning are handled elsewhere.

A control state machine has three states. ST_CLEAR means zeroed and idle. ST_RUN means counting. ST_HOLD means stopped with its values kept. The transitions are: ST_CLEAR to ST_RUN on start/stop; ST_RUN to ST_HOLD on start/stop; ST_HOLD to ST_RUN on start/stop; ST_HOLD to ST_CLEAR on an accepted clear or mode toggle. ST_CLEAR stays in ST_CLEAR on an accepted clear or mode toggle.

Top module: `chrono_lapmem`

## Requirements
- R1: After reset, and after any accepted clear, these outputs are zero: run_time, lap_time, lap_num, entry_count, rcl_valid, best_valid and best_blink. Reset also leaves the block stopped and in lap mode (split_mode = 0).
- R2: The start_stop strobe toggles between running and stopped. Ticks advance run_time and lap_time only while running. A restart continues from the stopped values.
- R3: Times are BCD with these fields: [27:24] hours, [23:20] minute tens, [19:16] minute ones, [15:12] second tens, [11:8] second ones, [7:4] tenths, [3:0] hundredths. After HOUR_LIMIT:MIN_LIMIT:SEC_LIMIT.99 the next tick gives zero.
- R4: In lap mode, a capture stores the lap_time value present in that cycle. lap_time reads zero on the next cycle, and run_time is unaffected.
- R5: In split mode, a capture stores the run_time value present in that cycle. Neither counter is reset.
- R6: The sequence number is two-digit BCD and starts at 00. Each capture increments it and stores the new value, so the first entry is 01. After 99 it wraps to 00 and keeps cycling.
- R7: entry_count rises by one per capture and saturates at DEPTH. Once full, each capture discards the oldest entry.
- R8: The recall position starts at the oldest entry. rcl_next and rcl_prev step it and stop at the newest and oldest valid entries. rcl_rewind, a clear, or a mode toggle returns it to the oldest entry.
- R9: In lap mode the first capture always becomes best. A later lap becomes best only if it is strictly shorter, so on a tie the earlier lap stays best. Split captures never become best. rcl_is_best is 1 only while the recalled entry is the stored best lap.
- R10: Stopping never compares the partial lap, so best_time and best_num do not change at a stop.
- R11: best_blink is 1 on the cycle after a new best is captured. It then toggles every BLINK_HALF ticks, giving 2 Hz at the default of 25. It stays 0 once a later, non-best lap is captured.
- R12: mode_toggle is ignored while running. While stopped it flips split_mode and clears the block as in R1.
- R13: A capture is accepted only while running. A clear is accepted only while stopped.
- R14: When start_stop is asserted, record, clear and mode_toggle are ignored in that cycle. When two or more of those three strobes coincide, all of them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| tick | input | 1 | 100 Hz count enable |
| start_stop | input | 1 | Start/stop strobe |
| record | input | 1 | Lap or split capture strobe |
| clear | input | 1 | Reset-while-stopped strobe |
| mode_toggle | input | 1 | Lap/split switch strobe |
| rcl_next | input | 1 | Step recall toward newer entries |
| rcl_prev | input | 1 | Step recall toward older entries |
| rcl_rewind | input | 1 | Return recall to the oldest entry |
| running | output | 1 | Counting in progress |
| split_mode | output | 1 | 1 = split operation, 0 = lap operation |
| run_time | output | 28 | Elapsed time, BCD |
| lap_time | output | 28 | Current lap time, BCD |
| lap_num | output | 8 | Last sequence number, BCD |
| entry_count | output | 4 | Valid stored entries |
| rcl_valid | output | 1 | Store holds at least one entry |
| rcl_time | output | 28 | Time of the recalled entry |
| rcl_num | output | 8 | Sequence number of the recalled entry |
| rcl_is_best | output | 1 | Recalled entry is the best lap |
| best_valid | output | 1 | A best lap exists |
| best_time | output | 28 | Best lap time |
| best_num | output | 8 | Sequence number of the best lap |
| best_blink | output | 1 | 2 Hz best indicator |

## Verification
The lap-length sweep mixes longer and shorter laps with an exact tie to the earlier best. This separates a strict less-than comparison from a less-or-equal one and from "last lap wins". Twelve captures fill the store and walk past its end, which exposes pointer and oldest-first ordering errors. The recall sweep then presses past both ends to show that the position saturates instead of wrapping. Stop/restart, coincident strobes and toggles while running tell accepted events apart from ignored ones. A run of more than a hundred short splits crosses the 99-to-00 sequence boundary, and a full-period count on a reduced hour/minute configuration shows every BCD carry and the final wrap.

// File: rtl/chrono_pkg.sv
package chrono_pkg;

    typedef struct packed {
        logic [3:0] hr;
        logic [3:0] mt;
        logic [3:0] mo;
        logic [3:0] st;
        logic [3:0] so;
        logic [3:0] ct;
        logic [3:0] co;
    } ctime_t;

    typedef struct packed {
        ctime_t     t;
        logic [7:0] num;
    } centry_t;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_RUN   = 2'd1,
        ST_HOLD  = 2'd2
    } cstate_t;

    // Advance a two-digit BCD pair; bit 8 set means it wrapped past lim.
    function automatic logic [8:0] pair_step(input logic [3:0] tens,
                                             input logic [3:0] ones,
                                             input int lim);
        int v;
        v = int'(tens) * 10 + int'(ones);
        if (v >= lim)
            pair_step = 9'h100;
        else if (ones == 4'd9)
            pair_step = {1'b0, tens + 4'd1, 4'd0};
        else
            pair_step = {1'b0, tens, ones + 4'd1};
    endfunction

endpackage

// File: rtl/chrono_timer.sv
module chrono_timer
    import chrono_pkg::*;
#(
    parameter int HOUR_LIMIT = 9,
    parameter int MIN_LIMIT  = 59,
    parameter int SEC_LIMIT  = 59
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   zero,
    input  logic   inc,
    output ctime_t t
);

    ctime_t     nxt;
    logic [8:0] cc_s;
    logic [8:0] ss_s;
    logic [8:0] mm_s;

    always_comb begin
        nxt  = t;
        cc_s = pair_step(t.ct, t.co, 99);
        ss_s = pair_step(t.st, t.so, SEC_LIMIT);
        mm_s = pair_step(t.mt, t.mo, MIN_LIMIT);
        {nxt.ct, nxt.co} = cc_s[7:0];
        if (cc_s[8]) begin
            {nxt.st, nxt.so} = ss_s[7:0];
            if (ss_s[8]) begin
                {nxt.mt, nxt.mo} = mm_s[7:0];
                if (mm_s[8])
                    nxt.hr = (int'(t.hr) >= HOUR_LIMIT) ? 4'd0 : t.hr + 4'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            t <= '0;
        else if (zero)
            t <= '0;
        else if (inc)
            t <= nxt;
    end

endmodule

// File: rtl/chrono_ctrl.sv
module chrono_ctrl
    import chrono_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_stop,
    input  logic record,
    input  logic clear,
    input  logic mode_toggle,
    output logic running,
    output logic split_mode,
    output logic do_clear,
    output logic do_record
);

    cstate_t    state;
    cstate_t    state_nxt;
    logic [1:0] n_other;
    logic       single;
    logic       flip;

    // Arbitration: start/stop wins, otherwise exactly one other strobe.
    always_comb begin
        n_other = {1'b0, record} + {1'b0, clear} + {1'b0, mode_toggle};
        single  = !start_stop && (n_other == 2'd1);
    end

    // Output decode per state.
    always_comb begin
        do_record = 1'b0;
        do_clear  = 1'b0;
        flip      = 1'b0;
        unique case (state)
            ST_RUN: do_record = single && record;
            ST_CLEAR,
            ST_HOLD: begin
                do_clear = single && (clear || mode_toggle);
                flip     = single && mode_toggle;
            end
            default: ;
        endcase
    end

    // Next state.
    always_comb begin
        unique case (state)
            ST_CLEAR: state_nxt = start_stop ? ST_RUN : ST_CLEAR;
            ST_RUN:   state_nxt = start_stop ? ST_HOLD : ST_RUN;
            ST_HOLD:  state_nxt = start_stop ? ST_RUN :
                                  (do_clear ? ST_CLEAR : ST_HOLD);
            default:  state_nxt = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_CLEAR;
        else
            state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            split_mode <= 1'b0;
        else if (flip)
            split_mode <= !split_mode;
    end

    assign running = (state == ST_RUN);

endmodule

// File: rtl/chrono_store.sv
module chrono_store
    import chrono_pkg::*;
#(
    parameter  int DEPTH = 10,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  centry_t          wr_entry,
    input  logic             rcl_next,
    input  logic             rcl_prev,
    input  logic             rcl_rewind,
    output logic [CNT_W-1:0] count,
    output logic [PTR_W-1:0] wr_slot,
    output logic [PTR_W-1:0] rcl_slot,
    output logic             rcl_valid,
    output centry_t          rcl_entry
);

    centry_t          mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [CNT_W-1:0] pos;
    logic [PTR_W-1:0] oldest;
    logic [PTR_W:0]   sum;
    logic [PTR_W-1:0] addr;

    always_comb begin
        oldest = (count == CNT_W'(DEPTH)) ? wr_ptr : '0;
        sum    = {1'b0, oldest} + (PTR_W+1)'(pos);
        addr   = (sum >= (PTR_W+1)'(DEPTH)) ? PTR_W'(sum - (PTR_W+1)'(DEPTH))
                                            : PTR_W'(sum);
    end

    always_ff @(posedge clk) begin
        if (wr)
            mem[wr_ptr] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            count  <= '0;
        end else if (wr) begin
            wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (count != CNT_W'(DEPTH))
                count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr || rcl_rewind)
            pos <= '0;
        else if (rcl_next && (pos + 1'b1 < count))
            pos <= pos + 1'b1;
        else if (rcl_prev && (pos != '0))
            pos <= pos - 1'b1;
    end

    assign wr_slot   = wr_ptr;
    assign rcl_slot  = addr;
    assign rcl_valid = (count != '0);
    assign rcl_entry = rcl_valid ? mem[addr] : '0;

endmodule

// File: rtl/chrono_best.sv
module chrono_best
    import chrono_pkg::*;
#(
    parameter  int BLINK_HALF = 25,
    parameter  int PTR_W      = 4,
    localparam int BW         = $clog2(BLINK_HALF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             cand,
    input  ctime_t           cand_time,
    input  logic [7:0]       cand_num,
    input  logic             ovw,
    input  logic [PTR_W-1:0] ovw_slot,
    output logic             best_valid,
    output ctime_t           best_time,
    output logic [7:0]       best_num,
    output logic [PTR_W-1:0] best_slot,
    output logic             best_live,
    output logic             blink
);

    logic          take;
    logic          latest;
    logic          phase;
    logic [BW-1:0] cnt;

    assign take = cand && (!best_valid || (cand_time < best_time));

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            best_valid <= 1'b0;
            best_time  <= '0;
            best_num   <= '0;
            best_slot  <= '0;
            best_live  <= 1'b0;
            latest     <= 1'b0;
            phase      <= 1'b0;
            cnt        <= '0;
        end else if (take) begin
            best_valid <= 1'b1;
            best_time  <= cand_time;
            best_num   <= cand_num;
            best_slot  <= ovw_slot;
            best_live  <= 1'b1;
            latest     <= 1'b1;
            phase      <= 1'b1;
            cnt        <= '0;
        end else begin
            if (cand)
                latest <= 1'b0;
            if (ovw && (ovw_slot == best_slot))
                best_live <= 1'b0;
            if (tick) begin
                if (cnt == BW'(BLINK_HALF - 1)) begin
                    cnt   <= '0;
                    phase <= !phase;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign blink = latest && phase;

endmodule

// File: rtl/chrono_lapmem.sv
module chrono_lapmem
    import chrono_pkg::*;
#(
    parameter  int DEPTH      = 10,
    parameter  int HOUR_LIMIT = 9,
    parameter  int MIN_LIMIT  = 59,
    parameter  int SEC_LIMIT  = 59,
    parameter  int BLINK_HALF = 25,
    localparam int CNT_W      = $clog2(DEPTH + 1),
    localparam int PTR_W      = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start_stop,
    input  logic             record,
    input  logic             clear,
    input  logic             mode_toggle,
    input  logic             rcl_next,
    input  logic             rcl_prev,
    input  logic             rcl_rewind,
    output logic             running,
    output logic             split_mode,
    output logic [27:0]      run_time,
    output logic [27:0]      lap_time,
    output logic [7:0]       lap_num,
    output logic [CNT_W-1:0] entry_count,
    output logic             rcl_valid,
    output logic [27:0]      rcl_time,
    output logic [7:0]       rcl_num,
    output logic             rcl_is_best,
    output logic             best_valid,
    output logic [27:0]      best_time,
    output logic [7:0]       best_num,
    output logic             best_blink
);

    logic             do_clear;
    logic             do_record;
    ctime_t           tv [2];
    logic [1:0]       tz;
    logic [1:0]       ti;
    logic [7:0]       num_q;
    logic [7:0]       num_nxt;
    centry_t          new_e;
    centry_t          rcl_e;
    logic [PTR_W-1:0] wr_slot;
    logic [PTR_W-1:0] rcl_slot;
    logic [PTR_W-1:0] best_slot;
    logic             best_live;
    ctime_t           best_t;

    chrono_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_stop (start_stop),
        .record     (record),
        .clear      (clear),
        .mode_toggle(mode_toggle),
        .running    (running),
        .split_mode (split_mode),
        .do_clear   (do_clear),
        .do_record  (do_record)
    );

    // Index 0: elapsed counter, index 1: lap counter.
    assign tz[0] = do_clear;
    assign tz[1] = do_clear || (do_record && !split_mode);
    assign ti[0] = running && tick;
    assign ti[1] = running && tick;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_tmr
            chrono_timer #(
                .HOUR_LIMIT(HOUR_LIMIT),
                .MIN_LIMIT (MIN_LIMIT),
                .SEC_LIMIT (SEC_LIMIT)
            ) u_tmr (
                .clk  (clk),
                .rst_n(rst_n),
                .zero (tz[g]),
                .inc  (ti[g]),
                .t    (tv[g])
            );
        end
    endgenerate

    always_comb begin
        if (num_q == 8'h99)
            num_nxt = 8'h00;
        else if (num_q[3:0] == 4'd9)
            num_nxt = {num_q[7:4] + 4'd1, 4'd0};
        else
            num_nxt = num_q + 8'd1;
        new_e.t   = split_mode ? tv[0] : tv[1];
        new_e.num = num_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || do_clear)
            num_q <= '0;
        else if (do_record)
            num_q <= num_nxt;
    end

    chrono_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (do_clear),
        .wr        (do_record),
        .wr_entry  (new_e),
        .rcl_next  (rcl_next),
        .rcl_prev  (rcl_prev),
        .rcl_rewind(rcl_rewind),
        .count     (entry_count),
        .wr_slot   (wr_slot),
        .rcl_slot  (rcl_slot),
        .rcl_valid (rcl_valid),
        .rcl_entry (rcl_e)
    );

    chrono_best #(.BLINK_HALF(BLINK_HALF), .PTR_W(PTR_W)) u_best (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (do_clear),
        .tick      (tick),
        .cand      (do_record && !split_mode),
        .cand_time (tv[1]),
        .cand_num  (num_nxt),
        .ovw       (do_record),
        .ovw_slot  (wr_slot),
        .best_valid(best_valid),
        .best_time (best_t),
        .best_num  (best_num),
        .best_slot (best_slot),
        .best_live (best_live),
        .blink     (best_blink)
    );

    assign run_time    = tv[0];
    assign lap_time    = tv[1];
    assign lap_num     = num_q;
    assign rcl_time    = rcl_e.t;
    assign rcl_num     = rcl_e.num;
    assign best_time   = best_t;
    assign rcl_is_best = best_live && rcl_valid && (rcl_slot == best_slot);

endmodule

// File: rtl/chrono_lapmem_chk.sv
module chrono_lapmem_chk #(
    parameter  int DEPTH = 10,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             split_mode,
    input logic [27:0]      run_time,
    input logic [CNT_W-1:0] entry_count,
    input logic             best_valid,
    input logic [27:0]      best_time,
    input logic             best_blink
);

    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        entry_count <= CNT_W'(DEPTH));

    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_count != $past(entry_count)) |->
            (entry_count == $past(entry_count) + 1'b1 || entry_count == '0));

    a_r2_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(running) |-> (run_time == $past(run_time) || run_time == '0));

    a_r12_mode_kept_while_running: assert property (@(posedge clk) disable iff (!rst_n)
        $past(running) |-> (split_mode == $past(split_mode)));

    a_r9_best_never_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (best_valid && $past(best_valid)) |-> (best_time <= $past(best_time)));

    a_r11_blink_needs_best: assert property (@(posedge clk) disable iff (!rst_n)
        best_blink |-> best_valid);

endmodule

bind chrono_lapmem chrono_lapmem_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .running    (running),
    .split_mode (split_mode),
    .run_time   (run_time),
    .entry_count(entry_count),
    .best_valid (best_valid),
    .best_time  (best_time),
    .best_blink (best_blink)
);

// File: tb/test_chrono_lapmem.sv
`timescale 1ns/1ps
module test_chrono_lapmem;

    localparam int DEPTH = 10;
    localparam int HL    = 1;
    localparam int ML    = 1;
    localparam int SL    = 59;
    localparam int BH    = 25;
    localparam int PER   = (HL + 1) * (ML + 1) * (SL + 1) * 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, start_stop = 1'b0, record = 1'b0, clear = 1'b0;
    logic mode_toggle = 1'b0, rcl_next = 1'b0, rcl_prev = 1'b0, rcl_rewind = 1'b0;
    logic        running, split_mode, rcl_valid, rcl_is_best, best_valid, best_blink;
    logic [27:0] run_time, lap_time, rcl_time, best_time;
    logic [7:0]  lap_num, rcl_num, best_num;
    logic [3:0]  entry_count;

    chrono_lapmem #(
        .DEPTH(DEPTH), .HOUR_LIMIT(HL), .MIN_LIMIT(ML), .SEC_LIMIT(SL), .BLINK_HALF(BH)
    ) i_chrono_lapmem (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start_stop(start_stop),
        .record(record), .clear(clear), .mode_toggle(mode_toggle),
        .rcl_next(rcl_next), .rcl_prev(rcl_prev), .rcl_rewind(rcl_rewind),
        .running(running), .split_mode(split_mode), .run_time(run_time),
        .lap_time(lap_time), .lap_num(lap_num), .entry_count(entry_count),
        .rcl_valid(rcl_valid), .rcl_time(rcl_time), .rcl_num(rcl_num),
        .rcl_is_best(rcl_is_best), .best_valid(best_valid), .best_time(best_time),
        .best_num(best_num), .best_blink(best_blink)
    );

    always #4 clk = ~clk;

    int nchk = 0, nerr = 0;

    // Reference model state
    int m_run, m_lap, m_cnt, m_num, m_seq, m_pos;
    bit m_running, m_split;
    int e_t [DEPTH];
    int e_n [DEPTH];
    int e_s [DEPTH];
    bit b_valid, b_latest, b_phase;
    int b_time, b_num, b_seq, b_cnt;

    function automatic logic [27:0] tb_bcd(input int cs);
        int c, s, m, h, x;
        c = cs % 100;
        x = cs / 100;
        s = x % (SL + 1);
        x = x / (SL + 1);
        m = x % (ML + 1);
        h = (x / (ML + 1)) % (HL + 1);
        return {4'(h), 4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10),
                4'(c / 10), 4'(c % 10)};
    endfunction

    function automatic logic [7:0] tb_num(input int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        bit ib;
        chk({tag, " running"}, 32'(running), 32'(m_running));
        chk({tag, " split_mode"}, 32'(split_mode), 32'(m_split));
        chk({tag, " run_time"}, 32'(run_time), 32'(tb_bcd(m_run)));
        chk({tag, " lap_time"}, 32'(lap_time), 32'(tb_bcd(m_lap)));
        chk({tag, " lap_num"}, 32'(lap_num), 32'(tb_num(m_num)));
        chk({tag, " entry_count"}, 32'(entry_count), 32'(m_cnt));
        chk({tag, " rcl_valid"}, 32'(rcl_valid), 32'(m_cnt != 0));
        if (m_cnt != 0) begin
            ib = b_valid && (e_s[m_pos] == b_seq);
            chk({tag, " rcl_time"}, 32'(rcl_time), 32'(tb_bcd(e_t[m_pos])));
            chk({tag, " rcl_num"}, 32'(rcl_num), 32'(tb_num(e_n[m_pos])));
            chk({tag, " rcl_is_best"}, 32'(rcl_is_best), 32'(ib));
        end
        chk({tag, " best_valid"}, 32'(best_valid), 32'(b_valid));
        if (b_valid) begin
            chk({tag, " best_time"}, 32'(best_time), 32'(tb_bcd(b_time)));
            chk({tag, " best_num"}, 32'(best_num), 32'(tb_num(b_num)));
        end
        chk({tag, " best_blink"}, 32'(best_blink), 32'(b_latest && b_phase));
    endtask

    task automatic m_zero();
        m_run = 0; m_lap = 0; m_cnt = 0; m_num = 0; m_pos = 0;
        b_valid = 0; b_latest = 0; b_phase = 0; b_cnt = 0;
        b_time = 0; b_num = 0; b_seq = -1;
    endtask

    task automatic strobe(input bit ss, input bit rc, input bit cl, input bit tg,
                          input bit nx, input bit pv, input bit rw);
        start_stop = ss; record = rc; clear = cl; mode_toggle = tg;
        rcl_next = nx; rcl_prev = pv; rcl_rewind = rw;
        @(negedge clk);
        start_stop = 0; record = 0; clear = 0; mode_toggle = 0;
        rcl_next = 0; rcl_prev = 0; rcl_rewind = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            if (m_running) begin
                m_run = (m_run + 1) % PER;
                m_lap = (m_lap + 1) % PER;
            end
            if (b_cnt == BH - 1) begin
                b_cnt = 0;
                b_phase = !b_phase;
            end else begin
                b_cnt++;
            end
        end
    endtask

    task automatic do_ss();
        strobe(1, 0, 0, 0, 0, 0, 0);
        m_running = !m_running;
    endtask

    task automatic do_rec();
        int val;
        strobe(0, 1, 0, 0, 0, 0, 0);
        if (!m_running) return;
        val = m_split ? m_run : m_lap;
        m_num = (m_num + 1) % 100;
        m_seq++;
        if (m_cnt < DEPTH) begin
            e_t[m_cnt] = val; e_n[m_cnt] = m_num; e_s[m_cnt] = m_seq;
            m_cnt++;
        end else begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                e_t[i] = e_t[i+1]; e_n[i] = e_n[i+1]; e_s[i] = e_s[i+1];
            end
            e_t[DEPTH-1] = val; e_n[DEPTH-1] = m_num; e_s[DEPTH-1] = m_seq;
        end
        if (!m_split) begin
            if (!b_valid || val < b_time) begin
                b_valid = 1; b_time = val; b_num = m_num; b_seq = m_seq;
                b_latest = 1; b_phase = 1; b_cnt = 0;
            end else begin
                b_latest = 0;
            end
            m_lap = 0;
        end
    endtask

    task automatic do_clr();
        strobe(0, 0, 1, 0, 0, 0, 0);
        if (!m_running) m_zero();
    endtask

    task automatic do_tog();
        strobe(0, 0, 0, 1, 0, 0, 0);
        if (!m_running) begin
            m_zero();
            m_split = !m_split;
        end
    endtask

    task automatic do_next();
        strobe(0, 0, 0, 0, 1, 0, 0);
        if (m_pos + 1 < m_cnt) m_pos++;
    endtask

    task automatic do_prev();
        strobe(0, 0, 0, 0, 0, 1, 0);
        if (m_pos > 0) m_pos--;
    endtask

    task automatic do_rew();
        strobe(0, 0, 0, 0, 0, 0, 1);
        m_pos = 0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        m_running = 0; m_split = 0; m_seq = 0;
        m_zero();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // R2: ticks while stopped have no effect, restart continues
        ticks(5);
        check_all("R2 idle ticks");
        do_ss();
        ticks(1234);
        check_all("R2 R3 running");
        do_ss();
        ticks(100);
        check_all("R2 stopped");
        do_ss();
        ticks(66);
        check_all("R2 restart continues");

        // R13: clear ignored while running
        do_clr();
        check_all("R13 clear while running");

        // R4 R9 R7: lap sweep with a tie, more captures than depth
        for (int k = 0; k < 12; k++) begin
            int len;
            len = (k == 6) ? 320 : 400 - 20 * k + (((k % 3) == 2) ? 60 : 0);
            ticks(len);
            do_rec();
            check_all("R4 R6 R7 R9 lap sweep");
            @(negedge clk);
            check_all("R4 lap timer restarted");
        end

        // R8: recall walk past both ends
        do_rew();
        check_all("R8 rewind");
        for (int i = 0; i < DEPTH + 1; i++) begin
            do_next();
            check_all("R8 R9 recall next");
        end
        for (int i = 0; i < DEPTH + 1; i++) begin
            do_prev();
            check_all("R8 R9 recall prev");
        end

        // R11: new best blink phase
        ticks(100);
        do_rec();
        check_all("R11 new best blink on");
        ticks(BH - 1);
        check_all("R11 blink still on");
        ticks(1);
        check_all("R11 blink off");
        ticks(BH);
        check_all("R11 blink on again");

        // R10: stop with a short partial lap leaves best alone
        ticks(10);
        do_ss();
        check_all("R10 stop partial lap");
        ticks(5);
        check_all("R10 stopped");

        // R13: capture ignored while stopped
        do_rec();
        check_all("R13 record while stopped");

        // R14: start/stop wins over record; coincident others ignored
        strobe(1, 1, 0, 0, 0, 0, 0);
        m_running = !m_running;
        check_all("R14 start with record");
        ticks(7);
        strobe(1, 0, 1, 0, 0, 0, 0);
        m_running = !m_running;
        check_all("R14 stop with clear");
        strobe(0, 0, 1, 1, 0, 0, 0);
        check_all("R14 clear with toggle");

        // R12: toggle while running ignored
        do_ss();
        do_tog();
        check_all("R12 toggle while running");
        do_ss();
        do_tog();
        check_all("R12 R1 toggle while stopped");

        // R5: split captures
        do_ss();
        ticks(300);
        do_rec();
        check_all("R5 split capture 1");
        ticks(125);
        do_rec();
        check_all("R5 split capture 2");
        do_rew();
        check_all("R5 split recall");

        // R6: sequence number wrap
        for (int i = 0; i < 105; i++) begin
            ticks(1);
            do_rec();
            check_all("R6 R7 number sweep");
        end

        // R1 R3: clear and full-period wrap
        do_ss();
        do_clr();
        check_all("R1 clear while stopped");
        do_ss();
        ticks(PER - 1);
        check_all("R3 last count");
        ticks(1);
        check_all("R3 wrap to zero");

        finish_run();
    end

endmodule